// File: doc/BRIEF.md
# Indexed CD Controller Register Interface

This block is the byte-wide register front end of a CD data controller. A host selects a register by loading a 5-bit index, then issues a sequence of byte reads or writes. Every access moves the index to the next register, so a whole group of registers can be streamed without reloading the index. The registers cover the interface control and status, a 12-bit transfer byte counter, a 16-bit transfer address, two sets of sector header bytes, the block pointer and write address, and the decoder control and status registers.

Sector events from the decoder load the header sets and raise an active-low decoder interrupt flag. A transfer-end input from the data mover raises an active-low transfer-end flag. Certain accesses release these flags as a side effect. A one-shot timer releases a pending decoder flag on its own after a fixed number of clocks. The two enabled flag conditions are combined, under an external enable, into a single level-5 interrupt request. The data mover, the sector storage and the subcode and command ports sit outside this block.

Top module: `cdc_regif`

## Requirements
- R1: After `rst`, or after any write to index 0x0F (soft reset), the index is 0, interface status (index 0x01) reads 0xFF, status 3 reads 0x80, header set 0 reads 00,00,00,01 at indices 0x04..0x07, block pointer, count and address are 0, and both interrupt flags are high.
- R2: A read or write at index n leaves the index at (n+1) mod 32, and `ix_load` loads `ix_val` instead. Reads of unused indices (0x00, 0x10..0x1F) return 0.
- R3: Writes at 0x02/0x03 set the byte counter low byte and high nibble (upper 4 bits of the byte dropped). Writes at 0x04/0x05 set the address low and high bytes. Both show on `xfer_count`/`xfer_addr` one cycle later, and the counter reads back at 0x02/0x03.
- R4: Writing interface control (index 0x01: bit 6 transfer-end interrupt enable, bit 5 decoder interrupt enable, bit 1 output enable) with bit 1 clear sets status bits 3 (busy, active low) and 1 (transfer enable, active low) to 1.
- R5: A write at 0x06 with output enable set clears status bits 3 and 1 and clears `xfer_done`. With output enable clear it changes nothing.
- R6: A `xfer_end` pulse drives status bit 6 and `xfer_irq_n` to 0, sets bits 3 and 1, and sets `xfer_done`. A write at 0x07 drives `xfer_irq_n` back to 1.
- R7: A `sec_evt` while control 0 bit 7 (decode enable) is set stores `sec_hdr` into header set 0 and `sec_sub` into set 1 (byte 0 in bits 31:24), sets status 0 to 0x80 and status 3 to 0x00, and drives `dec_irq_n` and status bit 5 to 0. With bit 7 clear the event is ignored.
- R8: A read at 0x0F returns status 3, then sets it to 0x80, drives `dec_irq_n` to 1, and leaves the index at 0x10. Status 1 (0x0D) always reads 0.
- R9: Control 1 (write index 0x0B) bit 0 picks header set 1 for reads at 0x04..0x07; clear picks set 0.
- R10: Status 2 (read 0x0E) equals control 1 AND 0x08 when control 0 bit 4 (auto) is set, else control 1 AND 0x0C. It is refreshed on writes to either control register.
- R11: Writing control 0 (index 0x0A) with bit 7 clear drives `dec_irq_n` to 1.
- R12: `dec_irq_n` returns to 1 exactly TIMEOUT clock edges after the edge that accepted the sector event.
- R13: `lvl5_req` is registered and, one cycle after, equals `lvl5_en` AND ((not `dec_irq_n` AND decoder enable) OR (not `xfer_irq_n` AND transfer-end enable)).
- R14: A decoded sector with control 0 bit 2 set adds BLOCK_BYTES to both block pointer (read 0x08/0x09) and write address (read 0x0A/0x0B). With bit 2 clear neither moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ix_load | input | 1 | Load the register index |
| ix_val | input | 5 | Index value to load |
| wr_en | input | 1 | Write strobe at the current index |
| rd_en | input | 1 | Read strobe at the current index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sec_evt | input | 1 | Sector decoded pulse |
| sec_hdr | input | 32 | Sector header bytes |
| sec_sub | input | 32 | Sector subheader bytes |
| xfer_end | input | 1 | Transfer finished pulse from the data mover |
| lvl5_en | input | 1 | Level-5 interrupt enable |
| dec_irq_n | output | 1 | Decoder interrupt flag, active low |
| xfer_irq_n | output | 1 | Transfer-end interrupt flag, active low |
| lvl5_req | output | 1 | Combined level-5 interrupt request |
| xfer_count | output | 12 | Transfer byte counter |
| xfer_addr | output | 16 | Transfer address |
| xfer_done | output | 1 | Transfer complete flag |

## Verification
Read data, both flags, the counter, the address and the done flag all change at the first clock edge after the strobe. The level-5 request follows one edge later because it is computed from the registered flags. The decoder timeout lands exactly TIMEOUT edges after the sector edge. Inputs change on the falling edge and every output is compared on the following falling edge against a behavioural model that applies the same edge counts. Directed checks around the timeout sample one cycle before and at the release edge.

// File: rtl/cdc_regif_pkg.sv
package cdc_regif_pkg;
  localparam int IX_W  = 5;
  localparam int CNT_W = 12;
  localparam int ADR_W = 16;
  localparam int HDR_BYTES = 4;
  typedef logic [IX_W-1:0] ix_t;

  // write map
  localparam ix_t IX_IFC  = 5'h01;
  localparam ix_t IX_CNTL = 5'h02;
  localparam ix_t IX_CNTH = 5'h03;
  localparam ix_t IX_ADRL = 5'h04;
  localparam ix_t IX_ADRH = 5'h05;
  localparam ix_t IX_TRIG = 5'h06;
  localparam ix_t IX_ACK  = 5'h07;
  localparam ix_t IX_CTL0 = 5'h0A;
  localparam ix_t IX_CTL1 = 5'h0B;
  localparam ix_t IX_SRST = 5'h0F;
  // read map
  localparam ix_t IX_STS  = 5'h01;
  localparam ix_t IX_PTRL = 5'h08;
  localparam ix_t IX_PTRH = 5'h09;
  localparam ix_t IX_WADL = 5'h0A;
  localparam ix_t IX_WADH = 5'h0B;
  localparam ix_t IX_ST0  = 5'h0C;
  localparam ix_t IX_ST1  = 5'h0D;
  localparam ix_t IX_ST2  = 5'h0E;
  localparam ix_t IX_ST3  = 5'h0F;

  // interface status bit positions (all active low)
  localparam int S_XEI  = 6;
  localparam int S_DCI  = 5;
  localparam int S_BUSY = 3;
  localparam int S_XEN  = 1;

  localparam logic [7:0] ST3_IDLE = 8'h80;
  localparam logic [7:0] ST0_DEC  = 8'h80;
endpackage

// File: rtl/cdc_hdr_bank.sv
module cdc_hdr_bank #(
  parameter int BYTES = 4,
  parameter logic [8*BYTES-1:0] SET0_INIT = 32'h0000_0001
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     ld,
  input  logic [8*BYTES-1:0]       main_in,
  input  logic [8*BYTES-1:0]       sub_in,
  input  logic                     sel,
  input  logic [$clog2(BYTES)-1:0] byte_ix,
  output logic [7:0]               q
);
  localparam int W = 8 * BYTES;

  logic [W-1:0] set0, set1, cur;

  always_ff @(posedge clk) begin
    if (clr) begin
      set0 <= SET0_INIT;
      set1 <= '0;
    end else if (ld) begin
      set0 <= main_in;
      set1 <= sub_in;
    end
  end

  assign cur = sel ? set1 : set0;

  // byte 0 sits in the most significant lane
  always_comb begin
    q = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (byte_ix == k[$clog2(BYTES)-1:0]) q = cur[8*(BYTES-1-k) +: 8];
    end
  end

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (clr)
    !ld |=> $stable(set0) && $stable(set1)); // R7
endmodule

// File: rtl/cdc_dec_timer.sv
module cdc_dec_timer #(
  parameter int TIMEOUT = 67250
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= CW'(TIMEOUT - 1);
    end else if (expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (clr)
    run |-> cnt < CW'(TIMEOUT)); // R12
  AST_TMR_ONESHOT: assert property (@(posedge clk) disable iff (clr)
    (expire && !start) |=> !run); // R12
endmodule

// File: rtl/cdc_irq_gen.sv
module cdc_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic dci_n,
  input  logic xei_n,
  input  logic dcie,
  input  logic xeie,
  input  logic en,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= en && ((!dci_n && dcie) || (!xei_n && xeie));
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req); // R13
  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (dci_n && xei_n) |=> !req); // R13
endmodule

// File: rtl/cdc_regif.sv
module cdc_regif
  import cdc_regif_pkg::*;
#(
  parameter int TIMEOUT     = 67250,
  parameter int BLOCK_BYTES = 2352
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ix_load,
  input  logic [IX_W-1:0]        ix_val,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic                   sec_evt,
  input  logic [8*HDR_BYTES-1:0] sec_hdr,
  input  logic [8*HDR_BYTES-1:0] sec_sub,
  input  logic                   xfer_end,
  input  logic                   lvl5_en,
  output logic                   dec_irq_n,
  output logic                   xfer_irq_n,
  output logic                   lvl5_req,
  output logic [CNT_W-1:0]       xfer_count,
  output logic [ADR_W-1:0]       xfer_addr,
  output logic                   xfer_done
);
  localparam int HIX_W = $clog2(HDR_BYTES);
  localparam logic [ADR_W-1:0] BLK_STEP = ADR_W'(BLOCK_BYTES);

  ix_t        ix;
  logic [7:0] sts;
  logic       xeie, dcie, outen;
  logic       dec_en, auto_md, wr_blk;
  logic       hsel;
  logic [1:0] mf;
  logic [7:0] st0, st2, st3;
  logic [ADR_W-1:0] ptr, wad;
  logic [CNT_W-1:0] cnt;
  logic [ADR_W-1:0] adr;
  logic [7:0] hdr_q, rd_mux;
  logic       is_rd, srst, sec_take, clr_all, tmr_exp;

  assign is_rd    = rd_en && !wr_en;
  assign srst     = wr_en && (ix == IX_SRST);
  assign sec_take = sec_evt && dec_en;
  assign clr_all  = rst || srst;

  cdc_hdr_bank #(.BYTES(HDR_BYTES)) u_hdr (
    .clk(clk), .clr(clr_all), .ld(sec_take),
    .main_in(sec_hdr), .sub_in(sec_sub),
    .sel(hsel), .byte_ix(ix[HIX_W-1:0]), .q(hdr_q)
  );

  cdc_dec_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .clr(clr_all), .start(sec_take), .expire(tmr_exp)
  );

  cdc_irq_gen u_irq (
    .clk(clk), .rst(rst), .dci_n(sts[S_DCI]), .xei_n(sts[S_XEI]),
    .dcie(dcie), .xeie(xeie), .en(lvl5_en), .req(lvl5_req)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (ix)
      IX_STS:  rd_mux = sts;
      IX_CNTL: rd_mux = cnt[7:0];
      IX_CNTH: rd_mux = {4'h0, cnt[CNT_W-1:8]};
      5'h04, 5'h05, 5'h06, 5'h07: rd_mux = hdr_q;  // header bytes 0..3
      IX_PTRL: rd_mux = ptr[7:0];
      IX_PTRH: rd_mux = ptr[ADR_W-1:8];
      IX_WADL: rd_mux = wad[7:0];
      IX_WADH: rd_mux = wad[ADR_W-1:8];
      IX_ST0:  rd_mux = st0;
      IX_ST1:  rd_mux = 8'h00;
      IX_ST2:  rd_mux = st2;
      IX_ST3:  rd_mux = st3;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      ix <= '0;  sts <= 8'hFF;
      {xeie, dcie, outen} <= '0;
      {dec_en, auto_md, wr_blk} <= '0;
      hsel <= 1'b0;  mf <= '0;
      st0 <= '0;  st2 <= '0;  st3 <= ST3_IDLE;
      ptr <= '0;  wad <= '0;  cnt <= '0;  adr <= '0;
      xfer_done <= 1'b0;  rdata <= '0;
    end else begin
      if (ix_load)              ix <= ix_val;
      else if (wr_en || rd_en)  ix <= ix + 1'b1;

      if (tmr_exp) sts[S_DCI] <= 1'b1;

      if (xfer_end) begin
        sts[S_XEI]  <= 1'b0;
        sts[S_BUSY] <= 1'b1;
        sts[S_XEN]  <= 1'b1;
        xfer_done   <= 1'b1;
      end

      if (wr_en) begin
        case (ix)
          IX_IFC: begin
            xeie <= wdata[6];  dcie <= wdata[5];  outen <= wdata[1];
            if (!wdata[1]) begin
              sts[S_BUSY] <= 1'b1;
              sts[S_XEN]  <= 1'b1;
            end
          end
          IX_CNTL: cnt[7:0]       <= wdata;
          IX_CNTH: cnt[CNT_W-1:8] <= wdata[3:0];
          IX_ADRL: adr[7:0]       <= wdata;
          IX_ADRH: adr[ADR_W-1:8] <= wdata;
          IX_TRIG: if (outen) begin
            sts[S_BUSY] <= 1'b0;
            sts[S_XEN]  <= 1'b0;
            xfer_done   <= 1'b0;
          end
          IX_ACK: sts[S_XEI] <= 1'b1;
          IX_CTL0: begin
            dec_en <= wdata[7];  auto_md <= wdata[4];  wr_blk <= wdata[2];
            if (!wdata[7]) sts[S_DCI] <= 1'b1;
            st2 <= {4'h0, mf & (wdata[4] ? 2'b10 : 2'b11), 2'b00};
          end
          IX_CTL1: begin
            hsel <= wdata[0];  mf <= wdata[3:2];
            st2  <= {4'h0, wdata[3:2] & (auto_md ? 2'b10 : 2'b11), 2'b00};
          end
          default: ;
        endcase
      end

      if (is_rd) begin
        rdata <= rd_mux;
        if (ix == IX_ST3) begin
          st3        <= ST3_IDLE;
          sts[S_DCI] <= 1'b1;
        end
      end

      if (sec_take) begin
        st0        <= ST0_DEC;
        st3        <= 8'h00;
        sts[S_DCI] <= 1'b0;
        if (wr_blk) begin
          ptr <= ptr + BLK_STEP;
          wad <= wad + BLK_STEP;
        end
      end
    end
  end

  assign dec_irq_n  = sts[S_DCI];
  assign xfer_irq_n = sts[S_XEI];
  assign xfer_count = cnt;
  assign xfer_addr  = adr;

  AST_IX_STEP: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !ix_load && !srst) |=> ix == $past(ix) + 1'b1); // R2
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ix == IX_ACK) |=> xfer_irq_n); // R6
  AST_ST3_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (is_rd && ix == IX_ST3 && !sec_take) |=> (st3 == ST3_IDLE) && dec_irq_n); // R8
  AST_SEC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sec_evt && !dec_en && !wr_en && !rd_en) |=> $stable(st3) && $stable(ptr)); // R7
endmodule

// File: tb/cdc_regif_test.sv
module cdc_regif_test;
  localparam int TMO = 67250;
  localparam int BLK = 2352;

  logic        clk = 1'b0, rst = 1'b1;
  logic        ix_load = 0, wr_en = 0, rd_en = 0, sec_evt = 0, xfer_end = 0, lvl5_en = 0;
  logic [4:0]  ix_val = '0;
  logic [7:0]  wdata = '0;
  logic [31:0] sec_hdr = '0, sec_sub = '0;
  logic [7:0]  rdata;
  logic        dec_irq_n, xfer_irq_n, lvl5_req, xfer_done;
  logic [11:0] xfer_count;
  logic [15:0] xfer_addr;

  int nvec = 0, nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cdc_regif #(.TIMEOUT(TMO), .BLOCK_BYTES(BLK)) uut (
    .clk(clk), .rst(rst), .ix_load(ix_load), .ix_val(ix_val),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .sec_evt(sec_evt), .sec_hdr(sec_hdr), .sec_sub(sec_sub),
    .xfer_end(xfer_end), .lvl5_en(lvl5_en),
    .dec_irq_n(dec_irq_n), .xfer_irq_n(xfer_irq_n), .lvl5_req(lvl5_req),
    .xfer_count(xfer_count), .xfer_addr(xfer_addr), .xfer_done(xfer_done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced at each rising edge
  logic [4:0]  m_idx;
  logic [7:0]  m_ifc, m_c0;
  logic [11:0] m_cnt;
  logic [15:0] m_adr;
  logic        m_dci, m_xei, m_done, m_l5;
  int          m_tmr;

  always @(posedge clk) begin
    logic [4:0] cur;
    if (rst) begin
      m_idx = 0; m_ifc = 0; m_c0 = 0; m_cnt = 0; m_adr = 0;
      m_dci = 1; m_xei = 1; m_done = 0; m_l5 = 0; m_tmr = -1;
    end else begin
      m_l5 = lvl5_en && ((!m_dci && m_ifc[5]) || (!m_xei && m_ifc[6]));
      if (m_tmr > 0) begin
        m_tmr--;
        if (m_tmr == 0) begin m_dci = 1; m_tmr = -1; end
      end
      if (xfer_end) begin m_xei = 0; m_done = 1; end
      cur = m_idx;
      if (ix_load) m_idx = ix_val;
      else if (wr_en || rd_en) m_idx = m_idx + 5'd1;
      if (wr_en) begin
        case (cur)
          5'h01: m_ifc = wdata;
          5'h02: m_cnt[7:0] = wdata;
          5'h03: m_cnt[11:8] = wdata[3:0];
          5'h04: m_adr[7:0] = wdata;
          5'h05: m_adr[15:8] = wdata;
          5'h06: if (m_ifc[1]) m_done = 0;
          5'h07: m_xei = 1;
          5'h0A: begin m_c0 = wdata; if (!wdata[7]) m_dci = 1; end
          5'h0F: begin
            m_idx = 0; m_ifc = 0; m_c0 = 0; m_cnt = 0; m_adr = 0;
            m_dci = 1; m_xei = 1; m_done = 0; m_tmr = -1;
          end
          default: ;
        endcase
      end else if (rd_en && cur == 5'h0F) m_dci = 1;
      if (sec_evt && m_c0[7] && !(wr_en && cur == 5'h0F)) begin
        m_dci = 0; m_tmr = TMO;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R7 dec_irq_n vs model", {31'd0, dec_irq_n}, {31'd0, m_dci});
      chk("R6 xfer_irq_n vs model", {31'd0, xfer_irq_n}, {31'd0, m_xei});
      chk("R13 lvl5_req vs model", {31'd0, lvl5_req}, {31'd0, m_l5});
      chk("R3 xfer_count vs model", {20'd0, xfer_count}, {20'd0, m_cnt});
      chk("R3 xfer_addr vs model", {16'd0, xfer_addr}, {16'd0, m_adr});
      chk("R5 xfer_done vs model", {31'd0, xfer_done}, {31'd0, m_done});
    end
  end

  task automatic setix(input logic [4:0] v);
    ix_load = 1; ix_val = v; @(negedge clk); ix_load = 0;
  endtask
  task automatic wreg(input logic [7:0] d);
    wr_en = 1; wdata = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic rchk(string tag, input logic [7:0] exp);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(tag, {24'd0, rdata}, {24'd0, exp});
  endtask
  task automatic sector(input logic [31:0] h, input logic [31:0] s);
    sec_hdr = h; sec_sub = s; sec_evt = 1; @(negedge clk); sec_evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; lvl5_en = 1;
    // R1 / R2 reset state and index stepping
    rchk("R2 unused index 0 reads zero", 8'h00);
    rchk("R1 interface status after reset", 8'hFF);
    setix(5'h0F); rchk("R1 status 3 after reset", 8'h80);
    rchk("R2 index 0x10 reads zero", 8'h00);
    setix(5'h1F); rchk("R2 index 0x1F reads zero", 8'h00);
    rchk("R2 wrap to index 0", 8'h00);
    rchk("R2 wrap then index 1", 8'hFF);
    setix(5'h04);
    rchk("R1 header byte 0", 8'h00); rchk("R1 header byte 1", 8'h00);
    rchk("R1 header byte 2", 8'h00); rchk("R1 header byte 3", 8'h01);
    // R3 counter and address
    setix(5'h02); wreg(8'h34); wreg(8'hAB); wreg(8'hCD); wreg(8'hEF);
    chk("R3 counter value", {20'd0, xfer_count}, 32'h0B34);
    chk("R3 address value", {16'd0, xfer_addr}, 32'hEFCD);
    setix(5'h02); rchk("R3 counter low readback", 8'h34);
    rchk("R3 counter high nibble only", 8'h0B);
    // R5 trigger ignored while output disabled
    setix(5'h06); wreg(8'h00);
    setix(5'h01); rchk("R5 trigger ignored without output enable", 8'hFF);
    // R5 trigger with output enabled
    setix(5'h01); wreg(8'h62);
    setix(5'h06); wreg(8'h00);
    setix(5'h01); rchk("R5 trigger sets busy and enable active", 8'hF5);
    // R6 transfer end and R13 request
    xfer_end = 1; @(negedge clk); xfer_end = 0;
    chk("R6 xfer_irq_n low after end", {31'd0, xfer_irq_n}, 0);
    chk("R6 xfer_done set", {31'd0, xfer_done}, 1);
    @(negedge clk);
    chk("R13 level-5 request raised", {31'd0, lvl5_req}, 1);
    setix(5'h01); rchk("R6 status after transfer end", 8'hBF);
    lvl5_en = 0; @(negedge clk);
    chk("R13 request gated by enable", {31'd0, lvl5_req}, 0);
    setix(5'h07); wreg(8'h00);
    chk("R6 acknowledge releases flag", {31'd0, xfer_irq_n}, 1);
    lvl5_en = 1;
    // R4 abort
    setix(5'h06); wreg(8'h00);
    chk("R5 trigger clears done", {31'd0, xfer_done}, 0);
    setix(5'h01); wreg(8'h60);
    setix(5'h01); rchk("R4 output disable aborts transfer", 8'hFF);
    // R7 sector ignored with decode off
    sector(32'h11223344, 32'h55667788);
    chk("R7 ignored sector leaves flag", {31'd0, dec_irq_n}, 1);
    setix(5'h04); rchk("R7 ignored sector keeps header", 8'h00);
    // decode on with block writes, mode bits
    setix(5'h0A); wreg(8'h84);
    setix(5'h0B); wreg(8'h0C);
    sector(32'h11223344, 32'h55667788);
    chk("R7 decoder flag active", {31'd0, dec_irq_n}, 0);
    @(negedge clk);
    chk("R13 request from decoder flag", {31'd0, lvl5_req}, 1);
    setix(5'h04);
    rchk("R7 header byte 0", 8'h11); rchk("R7 header byte 1", 8'h22);
    rchk("R7 header byte 2", 8'h33); rchk("R7 header byte 3", 8'h44);
    rchk("R14 pointer low", 8'h30); rchk("R14 pointer high", 8'h09);
    rchk("R14 write address low", 8'h30); rchk("R14 write address high", 8'h09);
    rchk("R7 status 0 after sector", 8'h80);
    rchk("R8 status 1 reads zero", 8'h00);
    rchk("R10 status 2 manual mode", 8'h0C);
    rchk("R8 status 3 valid after sector", 8'h00);
    chk("R8 status 3 read releases decoder flag", {31'd0, dec_irq_n}, 1);
    rchk("R8 index moved to 0x10", 8'h00);
    setix(5'h0F); rchk("R8 status 3 back to idle", 8'h80);
    // R9 header set select
    setix(5'h0B); wreg(8'h0D);
    setix(5'h04);
    rchk("R9 subheader byte 0", 8'h55); rchk("R9 subheader byte 1", 8'h66);
    rchk("R9 subheader byte 2", 8'h77); rchk("R9 subheader byte 3", 8'h88);
    // R10 auto mode
    setix(5'h0A); wreg(8'h94);
    setix(5'h0E); rchk("R10 auto mode masks form", 8'h08);
    setix(5'h0B); wreg(8'h04);
    setix(5'h0E); rchk("R10 auto mode drops form bit", 8'h00);
    setix(5'h0A); wreg(8'h84);
    setix(5'h0E); rchk("R10 manual mode keeps form bit", 8'h04);
    // R11 decode disable releases flag
    sector(32'hA1A2A3A4, 32'hB1B2B3B4);
    chk("R11 flag active before disable", {31'd0, dec_irq_n}, 0);
    setix(5'h0A); wreg(8'h04);
    chk("R11 decode disable releases flag", {31'd0, dec_irq_n}, 1);
    setix(5'h08);
    rchk("R14 pointer low after two blocks", 8'h60);
    rchk("R14 pointer high after two blocks", 8'h12);
    // R12 timeout, block writes off
    setix(5'h0A); wreg(8'h80);
    sector(32'hC1C2C3C4, 32'hD1D2D3D4);
    chk("R12 flag active at start", {31'd0, dec_irq_n}, 0);
    repeat (TMO - 1) @(negedge clk);
    chk("R12 flag still active one edge early", {31'd0, dec_irq_n}, 0);
    @(negedge clk);
    chk("R12 flag released at timeout", {31'd0, dec_irq_n}, 1);
    setix(5'h08);
    rchk("R14 pointer frozen without block write", 8'h60);
    rchk("R14 pointer high frozen", 8'h12);
    // R1 soft reset
    setix(5'h0F); wreg(8'h00);
    rchk("R1 soft reset index 0", 8'h00);
    rchk("R1 soft reset status", 8'hFF);
    chk("R1 soft reset counter", {20'd0, xfer_count}, 0);
    chk("R1 soft reset address", {16'd0, xfer_addr}, 0);
    setix(5'h08); rchk("R1 soft reset pointer", 8'h00);
    setix(5'h07); rchk("R1 soft reset header set 0", 8'h01);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule